// File: doc/BRIEF.md
# Fabric Suspend Sequencer

The block steps a programmable-logic fabric into and out of a low-power hold state. An asynchronous sleep request enters through a two-flop synchronizer and a glitch filter. The filter has its own count for accepting a rise and its own count for accepting a fall.

Once a request is accepted, the sequencer works through a series of phases:
- It can first wait for an acknowledge from user logic. This wait is enabled by a configuration input.
- It strobes a capture of every pin's current data.
- After a programmable delay it drops the global write-enable, which freezes all clocked state.
- After a second delay it raises the global output-hold control. Each pin then takes its own suspend behaviour, and a pin set to hold-last-value drives the data captured earlier.
- The awake flag falls while the fabric is held.

On exit the sequencer does the reverse:
- The awake flag rises first.
- After one delay the write-enable returns.
- After a further delay the output hold is released.

The configuration-done flag stays high the whole time. If the request is withdrawn part way through entry, the phase in progress completes and the full exit sequence follows.

Top module: `susp_seq`

## Requirements
- R1: During reset and after it, with no request, `fab_we_o`=1, `out_hold_o`=0, `awake_o`=1, `ack_req_o`=0, `cap_stb_o`=0 and every `pin_mode_o` field is 0 (normal).
- R2: A request level change is accepted only after the synchronized input has differed from the accepted level on FILT_ON consecutive clocks (for a rise) or FILT_OFF consecutive clocks (for a fall). A shorter high pulse never changes any output.
- R3: With `ack_en_i`=0, `cap_stb_o` is high 3+FILT_ON clocks after `sleep_req_i` rises. `fab_we_o` falls `dly_wp_i`+1 clocks later.
- R4: With `ack_en_i`=1, an accepted request raises `ack_req_o` 3+FILT_ON clocks after the input rises, and the outputs hold while no acknowledge arrives. One clock after `ack_i` is sampled high, `cap_stb_o` pulses. `fab_we_o` falls `dly_wp_i`+1 clocks after that.
- R5: `out_hold_o` rises and `awake_o` falls `dly_hold_i`+1 clocks after `fab_we_o` falls. `awake_o` is low only while `out_hold_o`=1 and `fab_we_o`=0.
- R6: `cap_stb_o` is a single-clock pulse. While it is high, the capture register holds the `pin_d_i` value sampled at that clock. `pin_q_o` follows `pin_d_i` until `out_hold_o` rises. After that, pins in hold-last-value mode drive the captured bit.
- R7: Per-pin modes are 3-bit fields, with pin i at bits [3i+2:3i]. The codes are 0 normal, 1 hold-last-value, 2 float, 3 pull-up, 4 pull-down and 5 keeper. `pin_mode_o` equals `pin_attr_i` while `out_hold_o`=1 and is 0 otherwise.
- R8: On exit, `awake_o` rises 3+FILT_OFF clocks after `sleep_req_i` falls. `fab_we_o` rises `dly_we_i`+1 clocks later. `out_hold_o` falls `dly_rel_i`+1 clocks after that.
- R9: A request withdrawn during entry lets the running phase finish, then runs the exit sequence, and `awake_o` never falls. A request withdrawn while waiting for the acknowledge returns to the active state, and `ack_req_o` falls 3+FILT_OFF clocks after the drop. `out_hold_o` never falls while `fab_we_o`=0.
- R10: `cfg_done_o` is high from the first clock after reset and stays high, through suspend as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sleep_req_i | input | 1 | Asynchronous suspend request |
| ack_en_i | input | 1 | Enables the acknowledge handshake before entry |
| ack_i | input | 1 | Acknowledge from user logic |
| dly_wp_i | input | DW | Capture to write-protect delay, value+1 clocks |
| dly_hold_i | input | DW | Write-protect to output-hold delay, value+1 clocks |
| dly_we_i | input | DW | Awake to write-enable delay, value+1 clocks |
| dly_rel_i | input | DW | Write-enable to output-release delay, value+1 clocks |
| pin_d_i | input | NPIN | Live pin data |
| pin_attr_i | input | 3*NPIN | Per-pin suspend mode |
| fab_we_o | output | 1 | Global write-enable |
| out_hold_o | output | 1 | Global output-hold control |
| awake_o | output | 1 | Low while suspended |
| cfg_done_o | output | 1 | Configuration-done flag |
| cap_stb_o | output | 1 | Last-value capture strobe |
| ack_req_o | output | 1 | Request to user logic for an acknowledge |
| pin_mode_o | output | 3*NPIN | Effective per-pin drive select |
| pin_q_o | output | NPIN | Pin data, live or captured |

## Verification
The bench sweeps every pair of entry delays and a range of exit delays, and checks the spacing between edges arithmetically. A design with an off-by-one counter load, or one that starts the hold from the request instead of from the write-protect, would shift an edge by a clock. Pulses from one clock up to one past the filter count find a filter that accepts short glitches or that needs one sample too many. Requests withdrawn in the middle of the write-protect phase, the output delay or the acknowledge wait catch three faults: raising the hold on an aborted entry, letting `awake_o` fall, or releasing outputs while writes are still blocked. Changing the pin data between capture and hold shows whether the held value was sampled at the strobe or presented too early.

// File: rtl/susp_pkg.sv
package susp_pkg;
  typedef enum logic [2:0] {
    ST_ACTIVE, ST_WAIT_ACK, ST_WP_DLY, ST_OUT_DLY, ST_HELD, ST_WAKE, ST_WE_BACK
  } susp_state_e;

  typedef enum logic [2:0] {
    PM_NORMAL = 3'd0,
    PM_HOLD   = 3'd1,
    PM_FLOAT  = 3'd2,
    PM_PULLUP = 3'd3,
    PM_PULLDN = 3'd4,
    PM_KEEP   = 3'd5
  } pin_mode_e;
endpackage

// File: rtl/susp_filter.sv
module susp_filter #(
  parameter int ON_CNT  = 4,
  parameter int OFF_CNT = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic async_i,
  output logic level_o
);
  localparam int MAXC = (ON_CNT > OFF_CNT) ? ON_CNT : OFF_CNT;
  localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

  logic [1:0]    sync_q;
  logic          lvl_q;
  logic [CW-1:0] cnt_q, lim_m1;

  assign lim_m1 = lvl_q ? CW'(OFF_CNT - 1) : CW'(ON_CNT - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      lvl_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], async_i};
      if (sync_q[1] != lvl_q) begin
        if (cnt_q == lim_m1) begin
          lvl_q <= sync_q[1];
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else begin
        cnt_q <= '0;
      end
    end
  end

  assign level_o = lvl_q;
endmodule

// File: rtl/susp_fsm.sv
module susp_fsm
  import susp_pkg::*;
#(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ack_en_i,
  input  logic          ack_i,
  input  logic [DW-1:0] dly_wp_i,
  input  logic [DW-1:0] dly_hold_i,
  input  logic [DW-1:0] dly_we_i,
  input  logic [DW-1:0] dly_rel_i,
  output logic          cap_o,
  output logic          cap_stb_o,
  output logic          we_o,
  output logic          hold_o,
  output logic          awake_o,
  output logic          ack_req_o
);
  susp_state_e   st_q, st_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          we_q, we_d, hold_q, hold_d, stb_q, zero;

  assign zero = (cnt_q == '0);

  always_comb begin
    st_d   = st_q;
    cnt_d  = zero ? cnt_q : cnt_q - 1'b1;
    we_d   = we_q;
    hold_d = hold_q;
    cap_o  = 1'b0;
    unique case (st_q)
      ST_ACTIVE: if (req_i) begin
        if (ack_en_i) st_d = ST_WAIT_ACK;
        else begin
          st_d  = ST_WP_DLY;
          cnt_d = dly_wp_i;
          cap_o = 1'b1;
        end
      end
      ST_WAIT_ACK: if (!req_i) st_d = ST_ACTIVE;
        else if (ack_i) begin
          st_d  = ST_WP_DLY;
          cnt_d = dly_wp_i;
          cap_o = 1'b1;
        end
      ST_WP_DLY: if (zero) begin
        we_d = 1'b0;
        // abort: skip the output phase, go straight to exit
        if (req_i) begin st_d = ST_OUT_DLY; cnt_d = dly_hold_i; end
        else begin st_d = ST_WAKE; cnt_d = dly_we_i; end
      end
      ST_OUT_DLY: if (zero) begin
        hold_d = 1'b1;
        st_d   = req_i ? ST_HELD : ST_WAKE;
        cnt_d  = dly_we_i;
      end
      ST_HELD: if (!req_i) begin st_d = ST_WAKE; cnt_d = dly_we_i; end
      ST_WAKE: if (zero) begin
        we_d  = 1'b1;
        st_d  = ST_WE_BACK;
        cnt_d = dly_rel_i;
      end
      ST_WE_BACK: if (zero) begin
        hold_d = 1'b0;
        st_d   = ST_ACTIVE;
      end
      default: st_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_ACTIVE;
      cnt_q  <= '0;
      we_q   <= 1'b1;
      hold_q <= 1'b0;
      stb_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      we_q   <= we_d;
      hold_q <= hold_d;
      stb_q  <= cap_o;
    end
  end

  assign cap_stb_o = stb_q;
  assign we_o      = we_q;
  assign hold_o    = hold_q;
  assign awake_o   = (st_q != ST_HELD);
  assign ack_req_o = (st_q == ST_WAIT_ACK);
endmodule

// File: rtl/susp_pins.sv
module susp_pins
  import susp_pkg::*;
#(
  parameter int NPIN = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cap_i,
  input  logic              hold_i,
  input  logic [NPIN-1:0]   pin_d_i,
  input  logic [3*NPIN-1:0] pin_attr_i,
  output logic [3*NPIN-1:0] pin_mode_o,
  output logic [NPIN-1:0]   pin_q_o
);
  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic       cap_q;
    logic [2:0] attr;

    assign attr = pin_attr_i[3*i +: 3];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)    cap_q <= 1'b0;
      else if (cap_i) cap_q <= pin_d_i[i];
    end

    assign pin_mode_o[3*i +: 3] = hold_i ? attr : PM_NORMAL;
    assign pin_q_o[i] = (hold_i && attr == PM_HOLD) ? cap_q : pin_d_i[i];
  end
endmodule

// File: rtl/susp_seq.sv
module susp_seq #(
  parameter int NPIN     = 8,
  parameter int DW       = 4,
  parameter int FILT_ON  = 4,
  parameter int FILT_OFF = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sleep_req_i,
  input  logic              ack_en_i,
  input  logic              ack_i,
  input  logic [DW-1:0]     dly_wp_i,
  input  logic [DW-1:0]     dly_hold_i,
  input  logic [DW-1:0]     dly_we_i,
  input  logic [DW-1:0]     dly_rel_i,
  input  logic [NPIN-1:0]   pin_d_i,
  input  logic [3*NPIN-1:0] pin_attr_i,
  output logic              fab_we_o,
  output logic              out_hold_o,
  output logic              awake_o,
  output logic              cfg_done_o,
  output logic              cap_stb_o,
  output logic              ack_req_o,
  output logic [3*NPIN-1:0] pin_mode_o,
  output logic [NPIN-1:0]   pin_q_o
);
  logic req_lvl, cap, hold, done_q;

  susp_filter #(.ON_CNT(FILT_ON), .OFF_CNT(FILT_OFF)) i_filter (
    .clk_i, .rst_ni, .async_i(sleep_req_i), .level_o(req_lvl)
  );

  susp_fsm #(.DW(DW)) i_fsm (
    .clk_i, .rst_ni, .req_i(req_lvl), .ack_en_i, .ack_i,
    .dly_wp_i, .dly_hold_i, .dly_we_i, .dly_rel_i,
    .cap_o(cap), .cap_stb_o, .we_o(fab_we_o), .hold_o(hold),
    .awake_o, .ack_req_o
  );

  susp_pins #(.NPIN(NPIN)) i_pins (
    .clk_i, .rst_ni, .cap_i(cap), .hold_i(hold), .pin_d_i, .pin_attr_i,
    .pin_mode_o, .pin_q_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) done_q <= 1'b0;
    else         done_q <= 1'b1;
  end

  assign out_hold_o = hold;
  assign cfg_done_o = done_q;
endmodule

// File: rtl/susp_seq_chk.sv
module susp_seq_chk #(
  parameter int NPIN = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fab_we_o,
  input logic              out_hold_o,
  input logic              awake_o,
  input logic              cfg_done_o,
  input logic              cap_stb_o,
  input logic              ack_req_o,
  input logic [3*NPIN-1:0] pin_mode_o
);
  // R10
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_o |=> cfg_done_o);

  // R9
  release_after_we_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(out_hold_o) |-> fab_we_o);

  // R5
  asleep_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_o |-> (out_hold_o && !fab_we_o));

  // R6
  cap_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_stb_o |=> !cap_stb_o);

  // R4
  ack_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_o |-> (fab_we_o && !out_hold_o));

  // R7
  mode_normal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_hold_o |-> (pin_mode_o == '0));
endmodule

bind susp_seq susp_seq_chk #(.NPIN(NPIN)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .fab_we_o(fab_we_o), .out_hold_o(out_hold_o),
  .awake_o(awake_o), .cfg_done_o(cfg_done_o), .cap_stb_o(cap_stb_o),
  .ack_req_o(ack_req_o), .pin_mode_o(pin_mode_o)
);

// File: tb/test_susp_seq.sv
module test_susp_seq;
  localparam int CLK_PERIOD = 10;
  localparam int NPIN = 6, DW = 3, F_ON = 3, F_OFF = 2;
  localparam logic [NPIN-1:0] HOLD_MASK = 6'b000010;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, ack_en = 1'b0, ack = 1'b0;
  logic [DW-1:0] d_wp = '0, d_hold = '0, d_we = '0, d_rel = '0;
  logic [NPIN-1:0] pd = '0;
  logic [3*NPIN-1:0] attr;
  logic we, hold, awake, done, stb, ackr;
  logic [3*NPIN-1:0] mode;
  logic [NPIN-1:0] pq;

  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  for (genvar i = 0; i < NPIN; i++) begin : g_attr
    assign attr[3*i +: 3] = 3'(i);
  end

  susp_seq #(.NPIN(NPIN), .DW(DW), .FILT_ON(F_ON), .FILT_OFF(F_OFF)) i_susp_seq (
    .clk_i(clk), .rst_ni(rst_n), .sleep_req_i(req), .ack_en_i(ack_en), .ack_i(ack),
    .dly_wp_i(d_wp), .dly_hold_i(d_hold), .dly_we_i(d_we), .dly_rel_i(d_rel),
    .pin_d_i(pd), .pin_attr_i(attr), .fab_we_o(we), .out_hold_o(hold),
    .awake_o(awake), .cfg_done_o(done), .cap_stb_o(stb), .ack_req_o(ackr),
    .pin_mode_o(mode), .pin_q_o(pq)
  );

  task automatic chk(input bit ok, input string r, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  function automatic logic sig(input int sel);
    case (sel)
      0: return we;
      1: return hold;
      2: return awake;
      3: return stb;
      default: return ackr;
    endcase
  endfunction

  // counts negedges until signal sel equals val
  task automatic wait_for(input int sel, input logic val, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (sig(sel) != val && n < 300);
  endtask

  task automatic trace(input int k, input int drop_at, output int wf, output int wr,
                       output int hr, output int hf, output int ar, output int af,
                       output bit alow);
    logic pw, ph, pa;
    wf = -1; wr = -1; hr = -1; hf = -1; ar = -1; af = -1; alow = 0;
    pw = we; ph = hold; pa = ackr;
    for (int i = 1; i <= k; i++) begin
      @(negedge clk);
      if (pw && !we && wf < 0) wf = i;
      if (!pw && we && wr < 0) wr = i;
      if (!ph && hold && hr < 0) hr = i;
      if (ph && !hold && hf < 0) hf = i;
      if (!pa && ackr && ar < 0) ar = i;
      if (pa && !ackr && af < 0) af = i;
      if (!awake) alow = 1;
      pw = we; ph = hold; pa = ackr;
      if (i == drop_at) req = 1'b0;
    end
  endtask

  task automatic set_dly(input int w, input int g, input int a, input int r);
    d_wp = DW'(w); d_hold = DW'(g); d_we = DW'(a); d_rel = DW'(r);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, wf, wr, hr, hf, ar, af;
    bit alow;
    logic [NPIN-1:0] snap;

    // R1 reset state
    repeat (3) @(negedge clk);
    chk(we && !hold && awake && !ackr && !stb && mode == '0, "R1 in reset",
        {we, hold, awake, ackr, stb}, 5'b10100);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(we && !hold && awake && !ackr && !stb && mode == '0, "R1 idle",
        {we, hold, awake, ackr, stb}, 5'b10100);
    chk(done, "R10 after reset", done, 1);

    // R3 R5 R6 R7 R8: sweep entry delays, vary exit delays
    for (int w = 0; w < 4; w++) begin
      for (int g = 0; g < 4; g++) begin
        int a, r;
        a = (w + 2 * g) % 8;
        r = 7 - w - g;
        set_dly(w, g, a, r);
        snap = NPIN'(6'h2a ^ (w * 5 + g));
        pd = snap;
        @(negedge clk);
        req = 1'b1;
        wait_for(3, 1'b1, n);
        chk(n == 3 + F_ON, "R3 capture strobe delay", n, 3 + F_ON);
        pd = ~snap;
        wait_for(0, 1'b0, n);
        chk(n == w + 1, "R3 write-protect delay", n, w + 1);
        chk(pq == ~snap, "R6 live before hold", pq, ~snap);
        wait_for(1, 1'b1, n);
        chk(n == g + 1, "R5 hold delay", n, g + 1);
        chk(!awake, "R5 awake low", awake, 0);
        chk(done, "R10 high in suspend", done, 1);
        chk(pq == ((~snap & ~HOLD_MASK) | (snap & HOLD_MASK)), "R6 held value",
            pq, (~snap & ~HOLD_MASK) | (snap & HOLD_MASK));
        chk(mode == attr, "R7 mode in hold", mode, attr);
        req = 1'b0;
        wait_for(2, 1'b1, n);
        chk(n == 3 + F_OFF, "R8 awake rise", n, 3 + F_OFF);
        wait_for(0, 1'b1, n);
        chk(n == a + 1, "R8 write-enable return", n, a + 1);
        wait_for(1, 1'b0, n);
        chk(n == r + 1, "R8 output release", n, r + 1);
        chk(mode == '0, "R7 mode normal after exit", mode, 0);
        repeat (3) @(negedge clk);
      end
    end

    // R2 glitch sweep
    set_dly(2, 0, 0, 0);
    for (int len = 1; len <= F_ON + 1; len++) begin
      req = 1'b1;
      trace(30, len, wf, wr, hr, hf, ar, af, alow);
      if (len < F_ON) begin
        chk(wf == -1 && hr == -1 && !alow, "R2 short pulse ignored", wf, -1);
      end else begin
        chk(wf == 7 + 2, "R2 accepted pulse enters", wf, 9);
        chk(wr == 10 && hr == -1 && !alow, "R9 abort exit after filtered pulse", wr, 10);
      end
    end

    // R9 abort during write-protect delay
    set_dly(7, 0, 2, 1);
    req = 1'b1;
    trace(40, 7, wf, wr, hr, hf, ar, af, alow);
    chk(wf == 14, "R9 wp phase finishes", wf, 14);
    chk(wr == 17, "R9 we returns", wr, 17);
    chk(hr == -1 && !alow, "R9 no hold on wp abort", hr, -1);

    // R9 abort during output delay
    set_dly(0, 7, 1, 2);
    req = 1'b1;
    trace(40, 7, wf, wr, hr, hf, ar, af, alow);
    chk(wf == 7, "R9 we falls", wf, 7);
    chk(hr == 15, "R9 output phase finishes", hr, 15);
    chk(wr == 17, "R9 we returns", wr, 17);
    chk(hf == 20, "R9 release after we", hf, 20);
    chk(!alow, "R9 awake stays high", alow, 0);

    // R9 abort while waiting for ack
    ack_en = 1'b1;
    set_dly(1, 1, 1, 1);
    req = 1'b1;
    trace(30, 6, wf, wr, hr, hf, ar, af, alow);
    chk(ar == 3 + F_ON, "R4 ack request", ar, 3 + F_ON);
    chk(af == 6 + 3 + F_OFF, "R9 ack request withdrawn", af, 6 + 3 + F_OFF);
    chk(wf == -1 && hr == -1, "R9 no entry without ack", wf, -1);

    // R4 handshake with varying ack latency
    for (int d = 0; d < 4; d++) begin
      set_dly(d, 1, 0, 0);
      @(negedge clk);
      req = 1'b1;
      wait_for(4, 1'b1, n);
      chk(n == 3 + F_ON, "R4 ack request delay", n, 3 + F_ON);
      for (int k = 0; k < d + 2; k++) begin
        @(negedge clk);
        chk(we && !stb && ackr, "R4 waits for ack", {we, stb, ackr}, 3'b101);
      end
      ack = 1'b1;
      wait_for(3, 1'b1, n);
      chk(n == 1, "R4 capture after ack", n, 1);
      ack = 1'b0;
      wait_for(0, 1'b0, n);
      chk(n == d + 1, "R4 write-protect after ack", n, d + 1);
      wait_for(1, 1'b1, n);
      chk(n == 2, "R5 hold after handshake", n, 2);
      req = 1'b0;
      wait_for(1, 1'b0, n);
      chk(n == 3 + F_OFF + 2, "R8 full exit", n, 3 + F_OFF + 2);
      repeat (3) @(negedge clk);
    end

    chk(done, "R10 at end", done, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule